// File: doc/BRIEF.md
# Pattern Compare Receiver

This block is the receiving half of a link bit error tester. Software-side logic first fills an expected-pattern memory through a write port whose address pointer steps by one per write. The block then watches a received word stream. Each word is qualified by a strobe and an active-low valid flag. Every accepted word is compared against the memory entry at the current read address, and the address then steps on.

Comparison does not begin at once. The receiver arms itself when the valid flag goes from high to low, as seen on two strobed words in a row. That first valid word is checked against address 1, which matches a pattern whose word 0 keeps the flag high and whose word 1 pulls it low.

A word-size select chooses between comparing the whole word and comparing only a narrow field. When a mismatch occurs, the block does the following:

- It keeps the first offending word and its address.
- It counts the error.
- It pulses an active-low trigger.
- It raises a sticky halt flag.

A mode input decides whether the receiver then freezes or keeps checking. A second counter records completed passes through the memory. A clear input zeroes both counters. Dropping both the run and load inputs returns the block to idle.

Top module: `pattern_rx`

## Requirements
- R1: With run low and load_en high, each cycle with ld_we high writes ld_data to the current pointer and advances the pointer by one, wrapping after 2^ADDR_W entries. With run and load_en both low (idle), the pointer returns to 0, so a full load that starts from idle places word i at address i.
- R2: After idle, no word is compared until a strobed word has rx_dav_n=0 and the previous strobed word had rx_dav_n=1. That word is compared against address 1, and later strobed words with rx_dav_n=0 are compared against addresses 2, 3, and so on, wrapping to 0. Strobed words with rx_dav_n=1, and cycles with rx_stb low, are not compared and do not move the address.
- R3: With wide=1, all 20 bits take part in the comparison. With wide=0, only bits 9 down to 1 are compared, and differences in bit 0 or in bits 19 to 10 are ignored.
- R4: On the first mismatch after idle, err_word takes the received word and err_addr takes the compared address, one clock after the word is sampled. Both then hold until the block passes through idle, even if more errors occur.
- R5: err_cnt rises by one per mismatch. pass_cnt rises by one per compare at the last address (2^ADDR_W-1). Both are 16 bits and wrap to 0. clr=1 zeroes both on the next edge and overrides any increment in that cycle.
- R6: trig_n is low for exactly the one clock that follows each mismatching compare, and high otherwise.
- R7: halt_out goes high one clock after a mismatch and stays high until the block is idle, when it returns to 0.
- R8: With restart_mode=0, once halt_out is high no further word is compared, so the counters and the capture registers stay frozen. With restart_mode=1, compares continue and later errors are still counted.
- R9: After reset, trig_n=1, halt_out=0, and err_cnt, pass_cnt, err_word and err_addr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Run enable; low with load_en low means idle |
| load_en | input | 1 | Pattern load state when run is low |
| ld_we | input | 1 | Write one pattern word at the pointer |
| ld_data | input | DATA_W | Pattern word to store |
| wide | input | 1 | 1 compares all bits, 0 compares bits 9..1 |
| restart_mode | input | 1 | 1 keeps running after an error, 0 halts |
| clr | input | 1 | Zero both counters |
| rx_stb | input | 1 | Received word strobe |
| rx_dav_n | input | 1 | Active-low received data valid |
| rx_data | input | DATA_W | Received word |
| err_word | output | DATA_W | First mismatching word since idle |
| err_addr | output | ADDR_W | Address of that word |
| err_cnt | output | CNT_W | Error counter |
| pass_cnt | output | CNT_W | Completed passes counter |
| trig_n | output | 1 | Active-low one-clock error pulse |
| halt_out | output | 1 | Sticky error flag, cleared in idle |

## Verification
Every output is registered, so every result of a word sampled at one rising edge is due at that same edge:

- the counters
- the capture registers
- trig_n
- halt_out

None of them changes before that edge. The bench drives inputs just after a falling edge and applies the same input set to a behavioural reference model at the rising edge. It compares all six outputs at the next falling edge, which is exactly one edge after the stimulus. Directed checks for arming, masking, halting and counter wrap read the outputs at that same falling edge, one cycle after the word that should cause the effect.

// File: rtl/pattern_rx.sv
module pattern_rx #(
  parameter int DATA_W    = 20,
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 16,
  parameter int NARROW_LO = 1,
  parameter int NARROW_HI = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              load_en,
  input  logic              ld_we,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              wide,
  input  logic              restart_mode,
  input  logic              clr,
  input  logic              rx_stb,
  input  logic              rx_dav_n,
  input  logic [DATA_W-1:0] rx_data,
  output logic [DATA_W-1:0] err_word,
  output logic [ADDR_W-1:0] err_addr,
  output logic [CNT_W-1:0]  err_cnt,
  output logic [CNT_W-1:0]  pass_cnt,
  output logic              trig_n,
  output logic              halt_out
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = '1;
  localparam logic [DATA_W-1:0] NMASK =
    DATA_W'((64'd1 << (NARROW_HI + 1)) - (64'd1 << NARROW_LO));

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] ptr;
  logic              armed, prev_hi, cap;

  logic idle, loading, stopped, take, arm_evt, cmp, miss;
  logic [ADDR_W-1:0] cmp_addr;
  logic [DATA_W-1:0] mask;

  assign idle     = !run && !load_en;
  assign loading  = !run && load_en;
  assign stopped  = halt_out && !restart_mode;
  assign take     = run && !stopped && rx_stb;
  assign arm_evt  = take && !armed && prev_hi && !rx_dav_n;
  assign cmp      = arm_evt || (take && armed && !rx_dav_n);
  assign cmp_addr = armed ? ptr : ADDR_W'(1);
  assign mask     = wide ? '1 : NMASK;
  assign miss     = cmp && (((rx_data ^ mem[cmp_addr]) & mask) != '0);

  always_ff @(posedge clk)
    if (loading && ld_we) mem[ptr] <= ld_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      armed    <= 1'b0;
      prev_hi  <= 1'b0;
      cap      <= 1'b0;
      halt_out <= 1'b0;
      err_word <= '0;
      err_addr <= '0;
      trig_n   <= 1'b1;
    end else begin
      trig_n <= !miss;
      if (idle) begin
        ptr      <= '0;
        armed    <= 1'b0;
        prev_hi  <= 1'b0;
        cap      <= 1'b0;
        halt_out <= 1'b0;
      end else if (loading) begin
        if (ld_we) ptr <= ptr + 1'b1;
      end else if (take) begin
        prev_hi <= rx_dav_n;
        if (cmp) begin
          ptr   <= cmp_addr + 1'b1;
          armed <= 1'b1;
        end
        if (miss) begin
          halt_out <= 1'b1;
          if (!cap) begin
            cap      <= 1'b1;
            err_word <= rx_data;
            err_addr <= cmp_addr;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt  <= '0;
      pass_cnt <= '0;
    end else if (clr) begin
      err_cnt  <= '0;
      pass_cnt <= '0;
    end else begin
      if (miss) err_cnt <= err_cnt + 1'b1;
      if (cmp && cmp_addr == LAST) pass_cnt <= pass_cnt + 1'b1;
    end
  end

  p_idle_ptr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (ptr == '0 && !halt_out));

  p_capture_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_out && run) |=> ($stable(err_word) && $stable(err_addr)));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (err_cnt == '0 && pass_cnt == '0));

  p_trig_with_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_n |-> halt_out);

  p_halt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_out && run) |=> halt_out);

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && run && !clr) |=> ($stable(err_cnt) && $stable(pass_cnt) && $stable(ptr)));

endmodule

// File: tb/pattern_rx_bench.sv
module pattern_rx_bench;
  localparam int DW = 20;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run = 0, load_en = 0, ld_we = 0, wide = 1, restart_mode = 0, clr = 0;
  logic rx_stb = 0, rx_dav_n = 1;
  logic [DW-1:0] ld_data = '0, rx_data = '0;
  logic [DW-1:0] err_word;
  logic [AW-1:0] err_addr;
  logic [15:0] err_cnt, pass_cnt;
  logic trig_n, halt_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pattern_rx u_pattern_rx (
    .clk(clk), .rst_n(rst_n), .run(run), .load_en(load_en), .ld_we(ld_we),
    .ld_data(ld_data), .wide(wide), .restart_mode(restart_mode), .clr(clr),
    .rx_stb(rx_stb), .rx_dav_n(rx_dav_n), .rx_data(rx_data),
    .err_word(err_word), .err_addr(err_addr), .err_cnt(err_cnt),
    .pass_cnt(pass_cnt), .trig_n(trig_n), .halt_out(halt_out));

  logic [DW-1:0] pat [DEPTH];
  logic [DW-1:0] mm [DEPTH];
  int m_ptr, m_ea, m_err, m_pass, m_addr;
  bit m_armed, m_prev, m_cap, m_halt, m_trig, m_miss, m_arm, m_use;
  logic [DW-1:0] m_ew, m_msk;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_armed = 0; m_prev = 0; m_cap = 0; m_halt = 0; m_trig = 1;
      m_err = 0; m_pass = 0; m_ew = '0; m_ea = 0;
    end else begin
      m_miss = 0;
      if (!run) begin
        if (load_en) begin
          if (ld_we) begin mm[m_ptr] = ld_data; m_ptr = (m_ptr + 1) % DEPTH; end
        end else begin
          m_ptr = 0; m_armed = 0; m_prev = 0; m_cap = 0; m_halt = 0;
        end
      end else if (!(m_halt && !restart_mode) && rx_stb) begin
        m_arm = !m_armed && m_prev && !rx_dav_n;
        m_use = m_arm || (m_armed && !rx_dav_n);
        m_prev = rx_dav_n;
        if (m_use) begin
          m_addr = m_armed ? m_ptr : 1;
          m_msk = wide ? 20'hFFFFF : 20'h003FE;
          m_miss = ((rx_data ^ mm[m_addr]) & m_msk) != 0;
          m_ptr = (m_addr + 1) % DEPTH;
          m_armed = 1;
          if (m_addr == DEPTH - 1) m_pass = (m_pass + 1) % 65536;
          if (m_miss) begin
            m_err = (m_err + 1) % 65536;
            m_halt = 1;
            if (!m_cap) begin m_cap = 1; m_ew = rx_data; m_ea = m_addr; end
          end
        end
      end
      m_trig = !m_miss;
      if (clr) begin m_err = 0; m_pass = 0; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 err_word model", err_word, m_ew);
      chk("R4 err_addr model", err_addr, m_ea);
      chk("R5 err_cnt model", err_cnt, m_err);
      chk("R5 pass_cnt model", pass_cnt, m_pass);
      chk("R6 trig_n model", trig_n, m_trig);
      chk("R7 halt_out model", halt_out, m_halt);
    end
  end

  task automatic send(input bit dn, input logic [DW-1:0] d);
    @(negedge clk);
    rx_stb = 1; rx_dav_n = dn; rx_data = d;
  endtask

  task automatic gap();
    @(negedge clk);
    rx_stb = 0;
  endtask

  initial begin
    #(20ns * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      pat[i] = DW'((i * 40503 + 977) ^ (i << 11));
    end
    pat[0][1] = 1'b0;
    pat[1][1] = 1'b1;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 trig_n", trig_n, 1);
    chk("R9 halt_out", halt_out, 0);
    chk("R9 err_cnt", err_cnt, 0);
    chk("R9 pass_cnt", pass_cnt, 0);
    chk("R9 err_word", err_word, 0);
    chk("R9 err_addr", err_addr, 0);

    // R1 load a full pattern from idle
    load_en = 1;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); ld_we = 1; ld_data = pat[i];
    end
    @(negedge clk); ld_we = 0; load_en = 0;
    @(negedge clk); run = 1; wide = 1; restart_mode = 0;

    // R2 words before arming are ignored even if they differ
    send(0, ~pat[7]);
    send(1, ~pat[3]);
    send(1, pat[0]);
    send(0, pat[1]);
    for (int a = 2; a < DEPTH; a++) begin
      if (a == 50) begin gap(); send(1, 20'hABCDE); end
      send(0, pat[a]);
    end
    send(0, pat[0]);
    gap();
    chk("R1 R2 clean pass err_cnt", err_cnt, 0);
    chk("R5 pass_cnt after one pass", pass_cnt, 1);
    chk("R7 no halt on clean pass", halt_out, 0);

    // R4 single bit corruption at address 5, halt mode
    for (int a = 1; a <= 10; a++) begin
      send(0, (a == 5) ? (pat[5] ^ 20'h8) : pat[a]);
      if (a == 6) begin
        chk("R6 trig_n low after error", trig_n, 0);
        chk("R7 halt_out raised", halt_out, 1);
      end
      if (a == 7) chk("R6 trig_n back high", trig_n, 1);
    end
    gap();
    chk("R4 err_word captured", err_word, pat[5] ^ 20'h8);
    chk("R4 err_addr captured", err_addr, 5);
    chk("R8 halted err_cnt frozen", err_cnt, 1);
    send(0, ~pat[11]);
    gap();
    chk("R8 halted ignores mismatch", err_cnt, 1);
    chk("R7 halt held", halt_out, 1);

    // idle clears halt
    run = 0;
    @(negedge clk);
    chk("R7 halt cleared in idle", halt_out, 0);

    // R3 narrow mode with restart
    run = 1; wide = 0; restart_mode = 1;
    send(1, pat[0]);
    send(0, pat[1] ^ 20'h1);
    send(0, pat[2] ^ 20'h08000);
    gap();
    chk("R3 masked bits ignored", err_cnt, 1);
    send(0, pat[3] ^ 20'h10);
    send(0, pat[4] ^ 20'h200);
    send(0, pat[5]);
    gap();
    chk("R3 R8 narrow errors counted in restart mode", err_cnt, 3);
    chk("R4 first error held", err_addr, 3);
    chk("R4 first word held", err_word, pat[3] ^ 20'h10);

    // R5 clear
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    chk("R5 clear err_cnt", err_cnt, 0);
    chk("R5 clear pass_cnt", pass_cnt, 0);

    // R5 error counter wrap
    wide = 1;
    for (int k = 0; k < 65538; k++) send(0, ~pat[(6 + k) % DEPTH]);
    gap();
    chk("R5 err_cnt wraps", err_cnt, 2);
    chk("R5 pass_cnt count", pass_cnt, 256);

    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule